// File: doc/BRIEF.md
# I2C Client Event Flag Unit

This block sits on the client side of an I2C bus and watches SCL and SDA lines that are already synchronized to the system clock. It recognises start, repeated start and stop conditions. It counts the SCL clock pulses of each byte and shifts in the received bits. It also compares address bytes against a programmed own address in either 7-bit or 10-bit form. From these observations it raises sticky event flags at fixed points in each byte. Some flags fire on the 8th counted falling edge of SCL, when the byte is complete. Others fire on the 9th, at the acknowledge slot.

The host reads the flags from `flags_o`. It clears them with a write strobe: each bit written as 0 clears that flag. A per-flag enable vector selects which flags drive the single interrupt output. The unit never drives SDA, never stretches the clock and has no controller behaviour. It only observes the bus and reports events.

Top module: `i2c_client_event_flags`

## Requirements
- R1: After reset every bit of `flags_o` is 0 and `irq_o` is 0.
- R2: A cycle with `flag_wr_i` high clears every flag whose bit in `flag_wdata_i` is 0 and leaves the flags whose bit is 1 unchanged. A hardware set in the same cycle takes priority. Without a write, a set flag stays set.
- R3: `irq_o` is high exactly when some flag is set whose bit in `flag_en_i` is also 1.
- R4: SDA falling while SCL is high is a start condition. When the bus is idle it sets the start flag (bit 0). When no stop has been seen since the previous start, it sets only the restart flag (bit 1).
- R5: SDA rising while SCL is high is a stop condition. It sets the stop flag (bit 2) and returns the bus to idle.
- R6: With `mode_i[0]`=0 (7-bit addressing), the first byte after a start or restart sets the address flag (bit 3) on its 8th counted SCL fall. This happens only when byte bits [7:1] equal `own_addr_i[6:0]`. Bit 0 of that byte is the R/W bit.
- R7: The data-write flag (bit 4) sets on the 8th counted SCL fall of a data byte, only while the unit is addressed with R/W = 0.
- R8: The acknowledge-time flag (bit 5) sets on the 9th counted SCL fall of any byte while the unit is addressed.
- R9: With `mode_i[0]`=1 (10-bit addressing), a first byte of the form 11110, `own_addr_i[9:8]`, R/W = 0 sets the address flag but not the acknowledge-time flag. The next byte, if it equals `own_addr_i[7:0]`, sets the address flag on its 8th fall and the acknowledge-time flag on its 9th fall.
- R10: The byte-count flag (bit 6) sets on the 9th counted SCL fall of every byte when `byte_cnt_i` is 0.
- R11: `mode_i` values 4 and 5 are non-client modes. In them, bits 3, 4 and 5 never set. All other values are client modes.
- R12: Only an SCL fall that follows an SCL rise within the transfer is counted. The fall right after a start is therefore not counted. The count restarts at every start or restart and wraps to 1 after the 9th fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| mode_i | input | 3 | Operating mode; bit 0 selects 10-bit addressing; 4 and 5 are non-client |
| own_addr_i | input | 10 | Own client address (7-bit form uses bits 6:0) |
| byte_cnt_i | input | CNT_W | Remaining byte count supplied by the host |
| flag_wr_i | input | 1 | Host write strobe for the flag register |
| flag_wdata_i | input | 7 | Host write data; a 0 bit clears the flag |
| flag_en_i | input | 7 | Per-flag interrupt enable |
| flags_o | output | 7 | Event flags: 6 count, 5 ack-time, 4 write, 3 address, 2 stop, 1 restart, 0 start |
| irq_o | output | 1 | OR of the enabled flags |

## Verification
The bench drives a matching 7-bit write and a non-matching address. Between them they show whether the address compare gates the address, write and acknowledge flags. A 10-bit write splits the high-byte and low-byte stages, and so exposes any acknowledge flag raised too early. A restart issued after three bits shows whether the bit count is rebuilt from the restart rather than carried over. The same matching address sent in a non-client mode must leave no flag set. The flag state is checked between the 8th and 9th falls, which tells 8th-edge events apart from 9th-edge events. Masked interrupts and partial clear writes test the host side.

// File: rtl/i2c_evf_pkg.sv
package i2c_evf_pkg;
   localparam int FLAG_N   = 7;
   localparam int F_START  = 0;
   localparam int F_RSTART = 1;
   localparam int F_STOP   = 2;
   localparam int F_ADR    = 3;
   localparam int F_WR     = 4;
   localparam int F_ACKT   = 5;
   localparam int F_CNT    = 6;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ADDR1 = 2'd1,
      PH_ADDR2 = 2'd2,
      PH_DATA  = 2'd3
   } phase_t;

   // modes 4 and 5 are the only non-client encodings
   function automatic logic is_client(input logic [2:0] m);
      return !(m[2] && !m[1]);
   endfunction
endpackage

// File: rtl/i2c_evf_cond_det.sv
module i2c_evf_cond_det (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_p,
   output logic rstart_p,
   output logic stop_p,
   output logic scl_rise_p,
   output logic scl_fall_p,
   output logic busy_o
);
   logic scl_q, sda_q, busy_q;
   logic cond_s, cond_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   // SDA edge while SCL stays high
   assign cond_s = scl_q & scl_i & sda_q & ~sda_i;
   assign cond_p = scl_q & scl_i & ~sda_q & sda_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_q <= 1'b0;
      else if (cond_p) busy_q <= 1'b0;
      else if (cond_s) busy_q <= 1'b1;
   end

   assign start_p    = cond_s & ~busy_q;
   assign rstart_p   = cond_s & busy_q;
   assign stop_p     = cond_p;
   assign scl_rise_p = ~scl_q & scl_i;
   assign scl_fall_p = scl_q & ~scl_i;
   assign busy_o     = busy_q;
endmodule

// File: rtl/i2c_evf_byte_track.sv
module i2c_evf_byte_track
   import i2c_evf_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_i,
   input  logic             start_p,
   input  logic             rstart_p,
   input  logic             stop_p,
   input  logic             scl_rise_p,
   input  logic             scl_fall_p,
   input  logic [2:0]       mode_i,
   input  logic [9:0]       own_addr_i,
   input  logic [CNT_W-1:0] byte_cnt_i,
   output logic             adr_set_o,
   output logic             wr_set_o,
   output logic             ackt_set_o,
   output logic             cnt_set_o,
   output logic [3:0]       bitcnt_o
);
   localparam logic [3:0] LAST_BIT = 4'd7;
   localparam logic [3:0] ACK_BIT  = 4'd8;
   localparam logic [3:0] WRAP_AT  = 4'd9;
   localparam logic [4:0] HI_TAG   = 5'b11110;

   phase_t     phase, ph_nxt;
   logic [3:0] bitcnt;
   logic [7:0] sr;
   logic       rise_seen, addressed, rw, low_m;
   logic       adr_nxt, rw_nxt, low_nxt, hit;
   logic       fall_cnt, eighth, ninth, client;
   logic       ten, m7, m_hi, m_lo;

   generate
      if (TEN_BIT_EN) begin : g_ten
         assign ten  = mode_i[0];
         assign m_hi = (sr[7:3] == HI_TAG) && (sr[2:1] == own_addr_i[9:8]);
         assign m_lo = (sr == own_addr_i[7:0]);
      end else begin : g_seven
         assign ten  = 1'b0;
         assign m_hi = 1'b0;
         assign m_lo = 1'b0;
      end
   endgenerate

   assign m7       = (sr[7:1] == own_addr_i[6:0]);
   assign client   = is_client(mode_i);
   assign fall_cnt = scl_fall_p && rise_seen && (phase != PH_IDLE);
   assign eighth   = fall_cnt && (bitcnt == LAST_BIT);
   assign ninth    = fall_cnt && (bitcnt == ACK_BIT);

   always_comb begin
      ph_nxt  = phase;
      adr_nxt = addressed;
      rw_nxt  = rw;
      low_nxt = low_m;
      hit     = 1'b0;
      unique case (phase)
         PH_ADDR1: begin
            ph_nxt = PH_DATA;
            if (ten) begin
               if (m_hi && !sr[0]) begin
                  hit     = 1'b1;
                  ph_nxt  = PH_ADDR2;
                  adr_nxt = 1'b0;
               end else if (m_hi && sr[0] && low_m) begin
                  hit     = 1'b1;
                  adr_nxt = 1'b1;
                  rw_nxt  = 1'b1;
               end else begin
                  adr_nxt = 1'b0;
               end
            end else begin
               hit     = m7;
               adr_nxt = m7;
               rw_nxt  = sr[0];
            end
         end
         PH_ADDR2: begin
            hit     = m_lo;
            ph_nxt  = PH_DATA;
            adr_nxt = m_lo;
            low_nxt = m_lo;
            rw_nxt  = 1'b0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         bitcnt    <= '0;
         sr        <= '0;
         rise_seen <= 1'b0;
         addressed <= 1'b0;
         rw        <= 1'b0;
         low_m     <= 1'b0;
      end else if (stop_p) begin
         phase     <= PH_IDLE;
         bitcnt    <= '0;
         rise_seen <= 1'b0;
         addressed <= 1'b0;
         low_m     <= 1'b0;
      end else if (start_p || rstart_p) begin
         phase     <= PH_ADDR1;
         bitcnt    <= '0;
         rise_seen <= 1'b0;
         addressed <= 1'b0;
         if (start_p) low_m <= 1'b0;
      end else begin
         if (scl_rise_p && (phase != PH_IDLE)) begin
            sr        <= {sr[6:0], sda_i};
            rise_seen <= 1'b1;
         end
         if (fall_cnt) begin
            rise_seen <= 1'b0;
            bitcnt    <= (bitcnt == WRAP_AT) ? 4'd1 : bitcnt + 4'd1;
         end
         if (eighth) begin
            phase     <= ph_nxt;
            addressed <= adr_nxt;
            rw        <= rw_nxt;
            low_m     <= low_nxt;
         end
      end
   end

   assign adr_set_o  = eighth && hit && client;
   assign wr_set_o   = eighth && (phase == PH_DATA) && addressed && !rw && client;
   assign ackt_set_o = ninth && addressed && client;
   assign cnt_set_o  = ninth && (byte_cnt_i == '0);
   assign bitcnt_o   = bitcnt;
endmodule

// File: rtl/i2c_evf_flag_reg.sv
module i2c_evf_flag_reg #(
   parameter int FLAG_N = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_N-1:0] set_i,
   input  logic              wr_i,
   input  logic [FLAG_N-1:0] wdata_i,
   input  logic [FLAG_N-1:0] en_i,
   output logic [FLAG_N-1:0] flags_o,
   output logic              irq_o
);
   logic [FLAG_N-1:0] q;

   generate
      for (genvar k = 0; k < FLAG_N; k++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q[k] <= 1'b0;
            else if (set_i[k]) q[k] <= 1'b1;
            else if (wr_i && !wdata_i[k]) q[k] <= 1'b0;
         end
      end
   endgenerate

   assign flags_o = q;
   assign irq_o   = |(q & en_i);
endmodule

// File: rtl/i2c_client_event_flags.sv
module i2c_client_event_flags
   import i2c_evf_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter bit TEN_BIT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic [2:0]       mode_i,
   input  logic [9:0]       own_addr_i,
   input  logic [CNT_W-1:0] byte_cnt_i,
   input  logic             flag_wr_i,
   input  logic [6:0]       flag_wdata_i,
   input  logic [6:0]       flag_en_i,
   output logic [6:0]       flags_o,
   output logic             irq_o
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must be in 1..32");
      end
      if (FLAG_N != 7) begin : g_bad_flags
         $error("flag layout mismatch");
      end
   endgenerate

   logic start_p, rstart_p, stop_p, scl_rise_p, scl_fall_p, busy;
   logic adr_set, wr_set, ackt_set, cnt_set;
   logic [3:0] bitcnt;
   logic [FLAG_N-1:0] set_vec;

   i2c_evf_cond_det u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .start_p    (start_p),
      .rstart_p   (rstart_p),
      .stop_p     (stop_p),
      .scl_rise_p (scl_rise_p),
      .scl_fall_p (scl_fall_p),
      .busy_o     (busy)
   );

   i2c_evf_byte_track #(
      .CNT_W      (CNT_W),
      .TEN_BIT_EN (TEN_BIT_EN)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_i      (sda_i),
      .start_p    (start_p),
      .rstart_p   (rstart_p),
      .stop_p     (stop_p),
      .scl_rise_p (scl_rise_p),
      .scl_fall_p (scl_fall_p),
      .mode_i     (mode_i),
      .own_addr_i (own_addr_i),
      .byte_cnt_i (byte_cnt_i),
      .adr_set_o  (adr_set),
      .wr_set_o   (wr_set),
      .ackt_set_o (ackt_set),
      .cnt_set_o  (cnt_set),
      .bitcnt_o   (bitcnt)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[F_START]  = start_p;
      set_vec[F_RSTART] = rstart_p;
      set_vec[F_STOP]   = stop_p;
      set_vec[F_ADR]    = adr_set;
      set_vec[F_WR]     = wr_set;
      set_vec[F_ACKT]   = ackt_set;
      set_vec[F_CNT]    = cnt_set;
   end

   i2c_evf_flag_reg #(
      .FLAG_N (FLAG_N)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec),
      .wr_i    (flag_wr_i),
      .wdata_i (flag_wdata_i),
      .en_i    (flag_en_i),
      .flags_o (flags_o),
      .irq_o   (irq_o)
   );

   logic unused_busy;
   assign unused_busy = busy;
endmodule

// File: rtl/i2c_evf_checker.sv
module i2c_evf_checker
   import i2c_evf_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode_i,
   input logic              flag_wr_i,
   input logic [6:0]        flag_wdata_i,
   input logic [6:0]        flags_o,
   input logic [FLAG_N-1:0] set_vec,
   input logic              start_p,
   input logic              rstart_p,
   input logic              stop_p,
   input logic [3:0]        bitcnt
);
   logic nonclient;
   assign nonclient = mode_i[2] && !mode_i[1];

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr_i |=> ((flags_o & ~$past(flag_wdata_i) & ~$past(set_vec)) == '0));

   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_wr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

   assert_one_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_p, rstart_p, stop_p}));

   assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      nonclient |-> (set_vec[F_ACKT:F_ADR] == '0));

   assert_bitcnt_R12: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= 4'd9);

   assert_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[F_CNT] |=> flags_o[F_CNT]);
endmodule

bind i2c_client_event_flags i2c_evf_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_i       (mode_i),
   .flag_wr_i    (flag_wr_i),
   .flag_wdata_i (flag_wdata_i),
   .flags_o      (flags_o),
   .set_vec      (set_vec),
   .start_p      (start_p),
   .rstart_p     (rstart_p),
   .stop_p       (stop_p),
   .bitcnt       (bitcnt)
);

// File: tb/tb_i2c_client_event_flags.sv
`timescale 1ns/1ps
module tb_i2c_client_event_flags;
   localparam int H = 4;
   localparam logic [6:0] B_START = 7'h01, B_RST = 7'h02, B_STOP = 7'h04,
                          B_ADR = 7'h08, B_WR = 7'h10, B_ACKT = 7'h20, B_CNT = 7'h40;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1;
   logic [2:0] mode = 3'd0;
   logic [9:0] own = 10'h02A;
   logic [7:0] bcnt = 8'd5;
   logic fwr = 1'b0;
   logic [6:0] fwd = '0, fen = 7'h7F;
   logic [6:0] flags;
   logic irq;

   int checks = 0, errors = 0;
   logic [6:0] exp_f = '0;
   logic [7:0] q_val[$];
   string      q_tag[$];
   bit done = 0;

   always #2.5 clk = ~clk;

   i2c_client_event_flags dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .mode_i(mode),
      .own_addr_i(own), .byte_cnt_i(bcnt), .flag_wr_i(fwr), .flag_wdata_i(fwd),
      .flag_en_i(fen), .flags_o(flags), .irq_o(irq));

   // monitor: pops expected items and compares against outputs
   always @(negedge clk) begin
      if (q_val.size() > 0) begin
         logic [7:0] e;
         string t;
         e = q_val.pop_front();
         t = q_tag.pop_front();
         checks++;
         if ({irq, flags} !== e) begin
            errors++;
            $display("FAIL %s: actual irq=%b flags=%h expected irq=%b flags=%h",
                     t, irq, flags, e[7], e[6:0]);
         end
      end
   end

   task automatic expect_now(input string tag);
      q_val.push_back({|(exp_f & fen), exp_f});
      q_tag.push_back(tag);
      repeat (2) @(negedge clk);
   endtask

   task automatic hp();
      repeat (H) @(negedge clk);
   endtask

   task automatic bus_start();
      sda = 1'b1; hp(); scl = 1'b1; hp(); sda = 1'b0; hp(); scl = 1'b0; hp();
   endtask

   task automatic bus_stop();
      sda = 1'b0; hp(); scl = 1'b1; hp(); sda = 1'b1; hp();
   endtask

   task automatic clk_bit(input logic b);
      sda = b; hp(); scl = 1'b1; hp(); scl = 1'b0; hp();
   endtask

   task automatic send8(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) clk_bit(b[i]);
   endtask

   task automatic host_wr(input logic [6:0] d);
      fwd = d; fwr = 1'b1; @(negedge clk); fwr = 1'b0; hp();
      exp_f = exp_f & d;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; hp();
      expect_now("R1 reset state");

      // 7-bit matching write, own address 0x2A -> 0x54
      bus_start(); exp_f |= B_START; expect_now("R4 start flag");
      send8(8'h54); exp_f |= B_ADR; expect_now("R6 address match at 8th fall");
      clk_bit(1'b0); exp_f |= B_ACKT; expect_now("R8 ack-time at 9th fall");
      host_wr(7'h00); expect_now("R2 clear all");
      send8(8'hA5); exp_f |= B_WR; expect_now("R7 data write at 8th fall");
      clk_bit(1'b0); exp_f |= B_ACKT; expect_now("R10 no count flag with nonzero count");
      bcnt = 8'd0;
      send8(8'h11); expect_now("R7 write flag sticky, R10 not yet");
      clk_bit(1'b0); exp_f |= B_CNT; expect_now("R10 count flag at 9th fall with zero");
      host_wr(B_CNT); expect_now("R2 partial clear keeps 1 bits");
      host_wr(7'h7F); expect_now("R2 all-ones write changes nothing");
      bus_stop(); exp_f |= B_STOP; expect_now("R5 stop flag");
      host_wr(7'h00); expect_now("R2 clear after stop");

      // restart mid-byte resets the bit counter
      bcnt = 8'd3;
      bus_start(); exp_f |= B_START; host_wr(7'h00);
      clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
      bus_start(); exp_f |= B_RST; expect_now("R4 restart sets only restart flag");
      for (int i = 7; i >= 1; i--) clk_bit(8'h54 >> i);
      expect_now("R12 no address flag after 7 counted falls");
      clk_bit(1'b0); exp_f |= B_ADR; expect_now("R12 address flag on 8th after restart");
      clk_bit(1'b0); exp_f |= B_ACKT; expect_now("R8 ack-time after restart");
      bus_stop(); exp_f |= B_STOP; host_wr(7'h00);

      // non-matching address
      bus_start(); host_wr(7'h00);
      send8(8'h56); clk_bit(1'b0); expect_now("R6 no address flag on mismatch");
      send8(8'h33); clk_bit(1'b0); expect_now("R7 no write flag when not addressed");
      bus_stop(); host_wr(7'h00);

      // non-client mode
      mode = 3'd4;
      bus_start(); host_wr(7'h00);
      send8(8'h54); clk_bit(1'b0); send8(8'h01); clk_bit(1'b0);
      expect_now("R11 non-client mode sets no byte flags");
      bus_stop(); host_wr(7'h00);

      // 10-bit write, own 0x2B5: high byte 0xF4, low byte 0xB5
      mode = 3'd1; own = 10'h2B5;
      bus_start(); host_wr(7'h00);
      send8(8'hF4); exp_f |= B_ADR; expect_now("R9 high byte sets address flag");
      clk_bit(1'b0); expect_now("R9 high write byte gives no ack-time");
      host_wr(7'h00);
      send8(8'hB5); exp_f |= B_ADR; expect_now("R9 low byte sets address flag");
      clk_bit(1'b0); exp_f |= B_ACKT; expect_now("R9 ack-time after low byte");
      send8(8'h77); exp_f |= B_WR; expect_now("R7 write flag in 10-bit mode");
      clk_bit(1'b0);
      bus_stop(); exp_f |= B_STOP; host_wr(7'h00);

      // interrupt masking
      fen = B_STOP;
      bus_start(); exp_f |= B_START; expect_now("R3 masked start gives no irq");
      bus_stop(); exp_f |= B_STOP; expect_now("R3 enabled stop raises irq");
      host_wr(7'h00); expect_now("R3 irq drops after clear");

      repeat (4) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule